// File: doc/BRIEF.md
# Byte-Serial SPI Master Engine

This block is the shifting core of a register-programmed SPI master. Configuration
fields (enable, soft reset, start, clock polarity, clock phase, bit order, chip-select
index, chip-select polarity, manual chip-select control and a burst length in bytes)
arrive as plain control pins. Once started, the engine exchanges the programmed number
of bytes full-duplex. Each outgoing byte is taken from an upstream transmit FIFO and
each incoming byte is handed to a downstream receive FIFO. A single-cycle `done` pulse
marks the end of the burst.

Shifting is paced by `sclk_tick`, a one-cycle enable from an external divider. Each
tick is one half period of the serial clock, so a byte takes sixteen ticks. Transmit
data uses a valid/ready pair. `tx_ready` is high for exactly one cycle at the start of
each byte, and a byte moves only when `tx_valid` is also high. If `tx_valid` is low at
that moment, the engine does not wait: it shifts 0x00 and consumes nothing. Receive
data has no back-pressure. `rx_valid` is a one-cycle push strobe, and the downstream
FIFO must accept every push.

Top module: `spi_xfer_engine`

## Requirements
- R1: A burst starts when `cfg_start` is high while the engine is idle, `cfg_enable` is 1, `cfg_soft_reset` is 0 and `cfg_burst_len` is nonzero. The start is ignored if `cfg_enable` is 0 or if `cfg_burst_len` is 0. `busy` stays 1 from the cycle after the start until the burst ends.
- R2: Exactly `cfg_burst_len` bytes are exchanged. `done` is then high for one cycle, in the same cycle that `busy` returns to 0.
- R3: `sclk` rests at `cfg_cpol` while idle. During a burst, every `sclk_tick` toggles `sclk`, with 16 toggles per byte, so `sclk` ends each byte back at `cfg_cpol`.
- R4: With `cfg_cpha`=0, MOSI is valid before the first (leading) SCLK edge of each bit and MISO is sampled on that edge. With `cfg_cpha`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: With `cfg_lsb_first`=1, bit 0 of each transmit byte is sent first and the first received bit lands in bit 0. With `cfg_lsb_first`=0, bit 7 goes first and the first received bit lands in bit 7.
- R6: `tx_ready` is high for one cycle when a byte begins, and the byte is consumed only if `tx_valid` is high in that cycle. If `tx_valid` is low, 0x00 is shifted out instead.
- R7: After the final sampling edge of each byte, `rx_valid` is high for one cycle, with the assembled byte on `rx_data`.
- R8: With `cfg_cs_manual`=0, the line `cs_out[cfg_cs_sel]` (index 0 to 3) is active for the whole burst and every other line stays inactive. The active level is low when `cfg_cs_active_low`=1 and high when it is 0.
- R9: With `cfg_cs_manual`=1, `cs_out[cfg_cs_sel]` equals `cfg_cs_level` regardless of transfer activity, and the other lines stay at the inactive level.
- R10: Raising `cfg_soft_reset`, or dropping `cfg_enable`, during a burst returns the engine to idle on the next clock. `sclk` goes back to `cfg_cpol`, chip select is released and no `done` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Engine enable |
| cfg_soft_reset | input | 1 | Synchronous abort to idle |
| cfg_start | input | 1 | Start request |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: LSB first, 0: MSB first |
| cfg_cs_sel | input | 2 | Chip-select index |
| cfg_cs_manual | input | 1 | 1: chip select driven from cfg_cs_level |
| cfg_cs_level | input | 1 | Manual chip-select level |
| cfg_cs_active_low | input | 1 | Polarity of automatic chip select |
| cfg_burst_len | input | 16 | Bytes per burst |
| sclk_tick | input | 1 | Half-period pacing enable |
| miso | input | 1 | Serial data in |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte taken at byte start |
| rx_valid | output | 1 | Receive byte push strobe |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_out | output | 4 | Chip-select lines |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Burst finished pulse |

## Verification
A slave model in the bench captures MOSI on the sampling edge implied by the configured phase and drives MISO from a pattern in wire order. Bursts are run in all four CPOL/CPHA combinations, mixed with both bit orders, using asymmetric byte values so that a mirrored byte or a wrong sampling edge gives a different result. A starved transmit source separates zero fill from stale data. A zero-length start and a start while disabled both show that no SCLK edge and no pop occurs. Automatic chip select with each polarity, manual chip select, and aborts in the middle of a burst are checked directly at the chip-select and SCLK pins.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} eng_state_e;

  function automatic logic lead_bit(input byte_t d, input logic lsb);
    return lsb ? d[0] : d[BYTE_W-1];
  endfunction

  function automatic byte_t drop_lead(input byte_t d, input logic lsb);
    return lsb ? (d >> 1) : (d << 1);
  endfunction

  function automatic byte_t take_bit(input byte_t d, input logic b, input logic lsb);
    return lsb ? {b, d[BYTE_W-1:1]} : {d[BYTE_W-2:0], b};
  endfunction
endpackage

// File: rtl/spi_phase_ctrl.sv
module spi_phase_ctrl
  import spi_eng_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             soft_reset,
  input  logic             start,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             tick,
  input  logic             cpol,
  input  logic             cpha,
  output logic             load,
  output logic             drive,
  output logic             sample,
  output logic             last_sample,
  output logic             sclk,
  output logic             busy,
  output logic             done
);
  localparam int PH_CNT  = 2 * BYTE_W;
  localparam int PH_W    = $clog2(PH_CNT);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PH_CNT - 1);
  localparam logic [PH_W-1:0] PH_PREV = PH_W'(PH_CNT - 2);

  eng_state_e       state_q;
  logic [PH_W-1:0]  phase_q;
  logic [LEN_W-1:0] left_q;
  logic             sclk_q, done_q;

  logic halt, kick, run_tick, byte_end, more;

  assign halt     = !enable || soft_reset;
  assign kick     = !halt && (state_q == ST_IDLE) && start && (burst_len != '0);
  assign run_tick = !halt && (state_q == ST_RUN) && tick;
  assign byte_end = run_tick && (phase_q == PH_LAST);
  assign more     = left_q > LEN_W'(1);

  assign load        = kick || (byte_end && more);
  assign sample      = run_tick && (phase_q[0] == cpha);
  assign drive       = run_tick && (phase_q[0] != cpha);
  assign last_sample = sample && (phase_q >= PH_PREV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      left_q  <= '0;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
    end else if (halt) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      left_q  <= '0;
      sclk_q  <= cpol;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == ST_IDLE) begin
        sclk_q <= cpol;
        if (kick) begin
          state_q <= ST_RUN;
          phase_q <= '0;
          left_q  <= burst_len;
        end
      end else if (run_tick) begin
        sclk_q <= ~sclk_q;
        if (byte_end) begin
          phase_q <= '0;
          if (more) begin
            left_q <= left_q - LEN_W'(1);
          end else begin
            left_q  <= '0;
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end else begin
          phase_q <= phase_q + PH_W'(1);
        end
      end
    end
  end

  assign sclk = sclk_q;
  assign busy = (state_q == ST_RUN);
  assign done = done_q;

  // done coincides with the fall of busy
  assert_done_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (state_q == ST_IDLE) && $past(state_q == ST_RUN));

  // a zero-length start leaves the engine idle
  assert_zero_len_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state_q == ST_IDLE && burst_len == '0) |=> (state_q == ST_IDLE));

  // serial clock rests at its idle level between bursts
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && state_q == ST_IDLE && $past(state_q == ST_IDLE) && $stable(cpol))
      |-> (sclk_q == cpol));

  // an abort never yields a completion pulse
  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!done_q && state_q == ST_IDLE));
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_eng_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  byte_t load_data,
  input  logic  drive,
  input  logic  sample,
  input  logic  last_sample,
  input  logic  cpha,
  input  logic  lsb_first,
  input  logic  miso,
  output logic  mosi,
  output byte_t rx_data,
  output logic  rx_valid
);
  byte_t tx_sh_q, rx_sh_q;
  logic  mosi_q, rx_valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh_q <= '0;
      mosi_q  <= 1'b0;
    end else if (load) begin
      if (!cpha) begin
        mosi_q  <= lead_bit(load_data, lsb_first);
        tx_sh_q <= drop_lead(load_data, lsb_first);
      end else begin
        tx_sh_q <= load_data;
      end
    end else if (drive) begin
      mosi_q  <= lead_bit(tx_sh_q, lsb_first);
      tx_sh_q <= drop_lead(tx_sh_q, lsb_first);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh_q    <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= last_sample;
      if (sample) begin
        rx_sh_q <= take_bit(rx_sh_q, miso, lsb_first);
      end
    end
  end

  assign mosi     = mosi_q;
  assign rx_data  = rx_sh_q;
  assign rx_valid = rx_valid_q;
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive #(
  parameter int CS_N  = 4,
  parameter int SEL_W = $clog2(CS_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  input  logic             manual,
  input  logic             level,
  input  logic             active_low,
  input  logic             busy,
  output logic [CS_N-1:0]  cs_o
);
  logic idle_lvl;
  assign idle_lvl = active_low;

  for (genvar i = 0; i < CS_N; i++) begin : g_line
    logic hit;
    assign hit = (sel == SEL_W'(i));
    always_comb begin
      if (!hit)        cs_o[i] = idle_lvl;
      else if (manual) cs_o[i] = level;
      else             cs_o[i] = busy ? ~idle_lvl : idle_lvl;
    end
  end

  // at most one line differs from the idle level in automatic mode
  assert_one_select_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !manual |-> $onehot0(cs_o ^ {CS_N{idle_lvl}}));
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CS_N  = 4,
  localparam int SEL_W = $clog2(CS_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_enable,
  input  logic              cfg_soft_reset,
  input  logic              cfg_start,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic [SEL_W-1:0]  cfg_cs_sel,
  input  logic              cfg_cs_manual,
  input  logic              cfg_cs_level,
  input  logic              cfg_cs_active_low,
  input  logic [LEN_W-1:0]  cfg_burst_len,
  input  logic              sclk_tick,
  input  logic              miso,
  input  logic              tx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi,
  output logic [CS_N-1:0]   cs_out,
  output logic              busy,
  output logic              done
);
  logic  load, drive, sample, last_sample;
  byte_t load_data;

  assign load_data = tx_valid ? tx_data : '0;
  assign tx_ready  = load;

  spi_phase_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable), .soft_reset(cfg_soft_reset),
    .start(cfg_start), .burst_len(cfg_burst_len), .tick(sclk_tick),
    .cpol(cfg_cpol), .cpha(cfg_cpha), .load(load), .drive(drive),
    .sample(sample), .last_sample(last_sample), .sclk(sclk), .busy(busy),
    .done(done)
  );

  spi_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .drive(drive), .sample(sample), .last_sample(last_sample),
    .cpha(cfg_cpha), .lsb_first(cfg_lsb_first), .miso(miso),
    .mosi(mosi), .rx_data(rx_data), .rx_valid(rx_valid)
  );

  spi_cs_drive #(.CS_N(CS_N), .SEL_W(SEL_W)) u_cs (
    .clk(clk), .rst_n(rst_n), .sel(cfg_cs_sel), .manual(cfg_cs_manual),
    .level(cfg_cs_level), .active_low(cfg_cs_active_low), .busy(busy),
    .cs_o(cs_out)
  );

  // a receive push only follows a cycle spent inside a burst
  assert_push_in_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(busy));

  // transmit pops happen only when a byte begins, never twice in a row
  assert_pop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);
endmodule

// File: tb/sim_spi_xfer_engine.sv
`timescale 1ns/1ps
module sim_spi_xfer_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cfg_enable = 1'b1, cfg_soft_reset = 1'b0, cfg_start = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
  logic [1:0] cfg_cs_sel = 2'd0;
  logic cfg_cs_manual = 1'b0, cfg_cs_level = 1'b1, cfg_cs_active_low = 1'b1;
  logic [15:0] cfg_burst_len = 16'd0;
  logic sclk_tick = 1'b0, miso = 1'b0, tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, rx_valid, sclk, mosi, busy, done;
  logic [7:0] rx_data;
  logic [3:0] cs_out;

  spi_xfer_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_soft_reset(cfg_soft_reset),
    .cfg_start(cfg_start), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cs_sel(cfg_cs_sel), .cfg_cs_manual(cfg_cs_manual),
    .cfg_cs_level(cfg_cs_level), .cfg_cs_active_low(cfg_cs_active_low),
    .cfg_burst_len(cfg_burst_len), .sclk_tick(sclk_tick), .miso(miso),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .rx_valid(rx_valid),
    .rx_data(rx_data), .sclk(sclk), .mosi(mosi), .cs_out(cs_out), .busy(busy), .done(done)
  );

  int checks = 0, failures = 0;
  logic [7:0] txq [0:7];
  logic [7:0] slv [0:7];
  logic [7:0] mosi_got [0:7];
  logic [7:0] rx_got [0:7];
  int tx_n = 0, tx_idx = 0, sidx = 0, nb = 0, rcount = 0, done_cnt = 0, edge_cnt = 0;
  logic pop_pend = 1'b0, prev_sclk = 1'b0;
  logic [7:0] cap = 8'h00;

  function automatic logic [7:0] rev8(input logic [7:0] d);
    for (int i = 0; i < 8; i++) rev8[i] = d[7-i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // pacing enable: one tick every second cycle
  initial forever begin
    @(negedge clk);
    sclk_tick <= !sclk_tick;
  end

  // transmit source, slave model and output monitor
  initial forever begin
    @(negedge clk);
    #1;
    if (pop_pend) begin
      tx_idx++;
      pop_pend = 1'b0;
    end
    tx_valid = (tx_idx < tx_n);
    tx_data  = (tx_idx < 8) ? txq[tx_idx] : 8'h00;
    if (tx_ready && tx_valid) pop_pend = 1'b1;
    if (sclk !== prev_sclk) begin
      edge_cnt++;
      if ((sclk != cfg_cpol) ^ cfg_cpha) begin
        cap = {cap[6:0], mosi};
        nb++;
        if (nb == 8) begin
          if (sidx < 8) mosi_got[sidx] = cap;
          nb = 0;
          sidx++;
        end
        miso = (sidx < 8) ? slv[sidx][7-nb] : 1'b0;
      end
    end
    prev_sclk = sclk;
    if (rx_valid) begin
      if (rcount < 8) rx_got[rcount] = rx_data;
      rcount++;
    end
    if (done) done_cnt++;
  end

  task automatic clear_state(input int ntx);
    @(negedge clk);
    #2;
    tx_n = ntx; tx_idx = 0; sidx = 0; nb = 0; rcount = 0; done_cnt = 0; edge_cnt = 0;
    pop_pend = 1'b0;
    miso = slv[0][7];
  endtask

  task automatic pulse_start();
    @(negedge clk);
    cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      #2;
      if (done_cnt > 0) break;
    end
  endtask

  // one full burst in a given mode, checking wire data, receive data and counts
  task automatic run_burst(input logic pol, input logic pha, input logic lsb,
                           input int len, input int ntx, input logic [7:0] seed);
    for (int i = 0; i < 8; i++) begin
      txq[i] = seed ^ 8'(i * 37 + 1);
      slv[i] = ~seed ^ 8'(i * 53 + 6);
    end
    cfg_cpol = pol; cfg_cpha = pha; cfg_lsb_first = lsb;
    cfg_cs_manual = 1'b0; cfg_cs_active_low = 1'b1; cfg_cs_sel = 2'd0;
    cfg_burst_len = 16'(len);
    repeat (3) @(negedge clk);
    clear_state(ntx);
    pulse_start();
    repeat (3) @(negedge clk);
    #2;
    chk("R1 busy during burst", busy, 1);
    chk("R8 cs0 active low during burst", cs_out, 4'b1110);
    wait_done();
    chk("R2 single done", done_cnt, 1);
    chk("R1 busy cleared", busy, 0);
    chk("R3 sclk idle after burst", sclk, pol);
    chk("R3 edge count", edge_cnt, 16 * len);
    chk("R6 bytes consumed", tx_idx + (pop_pend ? 1 : 0), (ntx < len) ? ntx : len);
    chk("R7 bytes pushed", rcount, len);
    for (int i = 0; i < len; i++) begin
      logic [7:0] src;
      src = (i < ntx) ? txq[i] : 8'h00;
      chk("R4 R5 R6 mosi byte", mosi_got[i], lsb ? rev8(src) : src);
      chk("R4 R5 R7 rx byte", rx_got[i], lsb ? rev8(slv[i]) : slv[i]);
    end
  endtask

  task automatic test_reset();
    #2;
    chk("R3 reset sclk", sclk, 0);
    chk("R8 reset cs", cs_out, 4'b1111);
    chk("R1 reset busy", busy, 0);
    chk("R7 reset rx_valid", rx_valid, 0);
    chk("R2 reset done", done, 0);
  endtask

  task automatic test_ignored_starts();
    cfg_burst_len = 16'd0;
    clear_state(2);
    pulse_start();
    repeat (40) @(negedge clk);
    #2;
    chk("R1 zero length busy", busy, 0);
    chk("R1 zero length edges", edge_cnt, 0);
    chk("R1 zero length pops", tx_idx, 0);
    chk("R2 zero length done", done_cnt, 0);
    cfg_burst_len = 16'd2;
    cfg_enable = 1'b0;
    clear_state(2);
    pulse_start();
    repeat (40) @(negedge clk);
    #2;
    chk("R1 disabled busy", busy, 0);
    chk("R1 disabled edges", edge_cnt, 0);
    cfg_enable = 1'b1;
  endtask

  task automatic test_manual_cs();
    cfg_cs_manual = 1'b1; cfg_cs_sel = 2'd1; cfg_cs_active_low = 1'b1;
    cfg_cs_level = 1'b0;
    @(negedge clk); #2;
    chk("R9 manual low", cs_out, 4'b1101);
    cfg_cs_level = 1'b1;
    @(negedge clk); #2;
    chk("R9 manual high", cs_out, 4'b1111);
    cfg_cs_sel = 2'd3; cfg_cs_level = 1'b0; cfg_burst_len = 16'd1;
    clear_state(1);
    pulse_start();
    wait_done();
    @(negedge clk); #2;
    chk("R9 manual holds after burst", cs_out, 4'b0111);
    cfg_cs_manual = 1'b0;
  endtask

  task automatic test_auto_high();
    cfg_cs_manual = 1'b0; cfg_cs_active_low = 1'b0; cfg_cs_sel = 2'd2;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_burst_len = 16'd1;
    clear_state(1);
    @(negedge clk); #2;
    chk("R8 active high idle", cs_out, 4'b0000);
    pulse_start();
    repeat (4) @(negedge clk); #2;
    chk("R8 active high cs2", cs_out, 4'b0100);
    wait_done();
    @(negedge clk); #2;
    chk("R8 active high released", cs_out, 4'b0000);
    cfg_cs_active_low = 1'b1; cfg_cs_sel = 2'd0;
  endtask

  task automatic test_abort(input logic use_enable);
    cfg_cpol = 1'b1; cfg_cpha = 1'b1; cfg_burst_len = 16'd4;
    clear_state(4);
    pulse_start();
    repeat (21) @(negedge clk);
    if (use_enable) cfg_enable = 1'b0; else cfg_soft_reset = 1'b1;
    @(negedge clk);
    cfg_enable = 1'b1; cfg_soft_reset = 1'b0;
    #2;
    chk("R10 abort busy", busy, 0);
    chk("R10 abort sclk", sclk, 1);
    chk("R10 abort cs", cs_out, 4'b1111);
    repeat (60) @(negedge clk); #2;
    chk("R10 abort no done", done_cnt, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin txq[i] = 8'h00; slv[i] = 8'h00; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_burst(1'b0, 1'b0, 1'b0, 3, 3, 8'hA5);
    run_burst(1'b1, 1'b1, 1'b1, 2, 2, 8'h3C);
    run_burst(1'b0, 1'b1, 1'b0, 2, 2, 8'h71);
    run_burst(1'b1, 1'b0, 1'b1, 1, 1, 8'hC2);
    run_burst(1'b0, 1'b0, 1'b1, 3, 1, 8'h96);
    test_ignored_starts();
    test_manual_cs();
    test_auto_high();
    test_abort(1'b0);
    test_abort(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule